// File: doc/BRIEF.md
# Frame-Timed Register Loader

This block holds a set of radio control channels whose new settings must take effect at one exact frame count. The processor reaches it through a small I/O port that inserts two wait states on every access. For each channel it writes a staged value and a reference count. A free-running frame counter steps on a frame tick. When the counter steps onto a channel's reference while that channel holds an unsent value, the staged value moves into the channel's active output and the channel strobe pulses for one cycle.

Channel 0 drives power ramp and receive gain. Its staged value is a start index into a small ramp RAM. On a channel 0 transfer the block plays out a programmed number of RAM entries, one entry per step tick, and wraps at the end of the RAM. Transmit and receive never overlap, so the processor rewrites the same RAM with ramp shapes before a transmit burst and with gain values before a receive window. Each staged write also opens a short busy window. This reflects the retiming of those registers into another clock domain, and a second write inside that window is flagged.

Top module: `frame_timed_loader`

## Requirements
- R1: After reset, frame_cnt, every active value, every strobe, ramp_level, ramp_run, spacing_err and io_ready are 0, and no channel is pending.
- R2: frame_cnt rises by one in each cycle after one in which frame_tick is high, steps from FRAME_MOD-1 to 0, and otherwise holds.
- R3: An access starts when io_sel rises. io_ready is high in the third cycle of io_sel (two wait states). A write commits at the end of that cycle. io_rdata is valid while io_ready is high.
- R4: A write to staging address 0x00+i (i < N_CH) stores the value and sets channel i pending. The active value of channel i is left unchanged.
- R5: When frame_tick steps the counter onto channel i's reference (address 0x08+i) while i is pending, the active value takes the staged value and ch_strobe[i] is high for that one cycle. The pending flag clears, and frame_cnt then equals the reference.
- R6: A staging write while the channel is pending replaces the staged value. Only the last value written is transferred.
- R7: A channel that is not pending makes no transfer and no strobe when the counter reaches its reference.
- R8: A reference of FRAME_MOD or above never matches. The channel stays pending.
- R9: A channel 0 transfer sets ramp_run, with start index = staged value bits [RAM_AW-1:0] and count = the ramp length register (address 0x10). On each step tick while running, ramp_level takes RAM[index] (RAM at 0x20+k) and the index advances modulo the RAM depth. ramp_run clears after the last entry.
- R10: Each staging write keeps that channel busy for SPACING cycles. A staging write inside that window pulses spacing_err for one cycle and is still accepted.
- R11: Reading status address 0x11 returns the pending flags in bits [N_CH-1:0] and the busy flags in bits [2*N_CH-1:N_CH]. Reads of staging, reference, length and RAM addresses return the stored values.
- R12: A channel 0 transfer with a ramp length of 0 leaves ramp_run low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_tick | input | 1 | Advances the frame counter |
| step_tick | input | 1 | Advances the ramp playout |
| io_sel | input | 1 | Processor access select, held until io_ready |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_addr | input | 6 | Register or RAM address |
| io_wdata | input | DATA_W | Write data |
| io_rdata | output | DATA_W | Read data, valid with io_ready |
| io_ready | output | 1 | End of the wait-state window |
| frame_cnt | output | FRAME_W | Current frame count |
| ch_active | output | N_CH*DATA_W | Active value of each channel, channel i at bits [i*DATA_W +: DATA_W] |
| ch_strobe | output | N_CH | One-cycle transfer pulse per channel |
| ramp_level | output | DATA_W | Current ramp or gain entry |
| ramp_run | output | 1 | Ramp playout in progress |
| spacing_err | output | 1 | Staging write inside the busy window |

## Verification
The bench builds the block with FRAME_MOD = 12 on a 4-bit counter, an 8-entry ramp RAM and SPACING = 5, with the default two wait states. The short modulus makes several counter wraps and repeated reference matches happen in a few hundred cycles. It also leaves the values 12 to 15 free as out-of-range references. The small RAM lets a ramp run across the wrap from the last entry to the first. The spacing of 5 is longer than one three-cycle access, so two back-to-back staging writes land inside the busy window.

// File: rtl/ftl_pkg.sv
// Package: shared constants, address regions and decode for the frame-timed loader.
// Assumes a 6-bit I/O address, N_CH <= 8 and RAM_AW <= 5.
package ftl_pkg;
    localparam int FTL_ADDR_W = 6;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_STAGE,
        RG_REF,
        RG_LEN,
        RG_STAT,
        RG_RAM
    } ftl_region_e;

    // Map an I/O address to the register region it selects.
    function automatic ftl_region_e ftl_decode(input logic [FTL_ADDR_W-1:0] a,
                                               input int n_ch, input int ram_aw);
        ftl_region_e r;
        r = RG_NONE;
        if (a[5]) begin
            if (int'(a[4:0]) < (1 << ram_aw)) r = RG_RAM;
        end else if (a[4:3] == 2'b00) begin
            if (int'(a[2:0]) < n_ch) r = RG_STAGE;
        end else if (a[4:3] == 2'b01) begin
            if (int'(a[2:0]) < n_ch) r = RG_REF;
        end else if (a == 6'h10) begin
            r = RG_LEN;
        end else if (a == 6'h11) begin
            r = RG_STAT;
        end
        return r;
    endfunction
endpackage

// File: rtl/ftl_io_port.sv
// Module: wait-state handshake for processor I/O accesses.
// Assumes the master holds io_sel and the access fields steady until it sees
// io_ready. One access completes per WAIT_STATES+1 cycles of io_sel.
module ftl_io_port #(
    parameter int WAIT_STATES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic io_sel,
    output logic io_ready,
    output logic commit
);
    localparam int CW = (WAIT_STATES < 1) ? 1 : $clog2(WAIT_STATES + 1);

    logic [CW-1:0] ws_cnt;
    logic          at_end;

    assign at_end   = (ws_cnt == CW'(WAIT_STATES));
    assign io_ready = io_sel && at_end;
    assign commit   = io_ready;

    // Count cycles of io_sel; restart after each completed access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_cnt <= '0;
        end else if (!io_sel || at_end) begin
            ws_cnt <= '0;
        end else begin
            ws_cnt <= ws_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ftl_frame_counter.sv
// Module: free-running frame counter, modulo FRAME_MOD, advanced by frame_tick.
// Also gives the value the counter takes at the next edge, for the compare units.
module ftl_frame_counter #(
    parameter int FRAME_W   = 6,
    parameter int FRAME_MOD = 52
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_tick,
    output logic [FRAME_W-1:0] cnt_q,
    output logic [FRAME_W-1:0] cnt_nxt
);
    localparam logic [FRAME_W-1:0] LAST = FRAME_W'(FRAME_MOD - 1);

    // Next count: wrap to zero after the last value, hold without a tick.
    always_comb begin
        if (!frame_tick)        cnt_nxt = cnt_q;
        else if (cnt_q == LAST) cnt_nxt = '0;
        else                    cnt_nxt = cnt_q + 1'b1;
    end

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nxt;
    end
endmodule

// File: rtl/ftl_channel.sv
// Module: one timed channel with staging register, reference, pending flag,
// active register, strobe and write-spacing window.
// Assumes cnt_nxt comes from the shared frame counter. A transfer uses the
// staged value held before any write in the same cycle.
module ftl_channel #(
    parameter int DATA_W  = 12,
    parameter int FRAME_W = 6,
    parameter int SPACING = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_tick,
    input  logic [FRAME_W-1:0] cnt_nxt,
    input  logic               stage_we,
    input  logic               ref_we,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  stage_q,
    output logic [FRAME_W-1:0] ref_q,
    output logic [DATA_W-1:0]  active_q,
    output logic               strobe_q,
    output logic               pending_q,
    output logic               busy,
    output logic               xfer,
    output logic               spacing_hit
);
    localparam int SW = (SPACING < 1) ? 1 : $clog2(SPACING + 1);

    logic [SW-1:0] busy_cnt;

    assign xfer        = frame_tick && pending_q && (cnt_nxt == ref_q);
    assign busy        = (busy_cnt != '0);
    assign spacing_hit = stage_we && busy;

    // Staging and reference registers, loaded by the processor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
            ref_q   <= '0;
        end else begin
            if (stage_we) stage_q <= wdata;
            if (ref_we)   ref_q   <= wdata[FRAME_W-1:0];
        end
    end

    // Pending flag: a write sets it, a transfer clears it, and a write wins.
    always_ff @(posedge clk) begin
        if (!rst_n)        pending_q <= 1'b0;
        else if (stage_we) pending_q <= 1'b1;
        else if (xfer)     pending_q <= 1'b0;
    end

    // Active register and one-cycle strobe on a match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= '0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= xfer;
            if (xfer) active_q <= stage_q;
        end
    end

    // Busy window that follows each staging write.
    always_ff @(posedge clk) begin
        if (!rst_n)        busy_cnt <= '0;
        else if (stage_we) busy_cnt <= SW'(SPACING);
        else if (busy)     busy_cnt <= busy_cnt - 1'b1;
    end
endmodule

// File: rtl/ftl_ramp_seq.sv
// Module: ramp/gain RAM and playout sequencer for channel 0.
// Assumes a start request outranks a step in the same cycle. A RAM write in
// the cycle of a step does not change the entry that step reads.
module ftl_ramp_seq #(
    parameter int DATA_W = 12,
    parameter int RAM_AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ram_we,
    input  logic [RAM_AW-1:0] ram_waddr,
    input  logic [DATA_W-1:0] ram_wdata,
    input  logic [RAM_AW-1:0] ram_raddr,
    output logic [DATA_W-1:0] ram_rdata,
    input  logic              start,
    input  logic [RAM_AW-1:0] start_idx,
    input  logic [RAM_AW:0]   len,
    input  logic              step_tick,
    output logic [DATA_W-1:0] level_q,
    output logic              run_q
);
    localparam int RAM_D = 1 << RAM_AW;

    logic [DATA_W-1:0] mem [RAM_D];
    logic [RAM_AW-1:0] idx_q;
    logic [RAM_AW:0]   left_q;

    assign ram_rdata = mem[ram_raddr];

    // RAM write port for the processor.
    always_ff @(posedge clk) begin
        if (ram_we) mem[ram_waddr] <= ram_wdata;
    end

    // Playout: load on start, then one entry per step tick until the count runs out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            left_q  <= '0;
            run_q   <= 1'b0;
            level_q <= '0;
        end else if (start) begin
            idx_q  <= start_idx;
            left_q <= len;
            run_q  <= (len != '0);
        end else if (step_tick && run_q) begin
            level_q <= mem[idx_q];
            idx_q   <= idx_q + 1'b1;
            left_q  <= left_q - 1'b1;
            if (left_q == (RAM_AW+1)'(1)) run_q <= 1'b0;
        end
    end
endmodule

// File: rtl/frame_timed_loader.sv
// Module: top of the frame-timed register loader. Decodes processor accesses,
// keeps the channels and the ramp sequencer, and drives the read-back path.
// Assumes DATA_W >= FRAME_W, DATA_W >= 2*N_CH, DATA_W >= RAM_AW+1,
// 2 <= N_CH <= 8 and RAM_AW <= 5.
module frame_timed_loader
    import ftl_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int FRAME_W     = 6,
    parameter int FRAME_MOD   = 52,
    parameter int N_CH        = 4,
    parameter int RAM_AW      = 4,
    parameter int WAIT_STATES = 2,
    parameter int SPACING     = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_tick,
    input  logic                     step_tick,
    input  logic                     io_sel,
    input  logic                     io_wr,
    input  logic [5:0]               io_addr,
    input  logic [DATA_W-1:0]        io_wdata,
    output logic [DATA_W-1:0]        io_rdata,
    output logic                     io_ready,
    output logic [FRAME_W-1:0]       frame_cnt,
    output logic [N_CH*DATA_W-1:0]   ch_active,
    output logic [N_CH-1:0]          ch_strobe,
    output logic [DATA_W-1:0]        ramp_level,
    output logic                     ramp_run,
    output logic                     spacing_err
);
    localparam int CH_IW = $clog2(N_CH);

    ftl_region_e        region;
    logic               commit;
    logic               wr_go;
    logic [CH_IW-1:0]   ch_sel;
    logic [FRAME_W-1:0] cnt_nxt;
    logic [RAM_AW:0]    len_q;
    logic [DATA_W-1:0]  ram_rdata;
    logic               err_q;

    logic [DATA_W-1:0]  stage_w  [N_CH];
    logic [FRAME_W-1:0] ref_w    [N_CH];
    logic [DATA_W-1:0]  active_w [N_CH];
    logic [N_CH-1:0]    pend_w;
    logic [N_CH-1:0]    busy_w;
    logic [N_CH-1:0]    xfer_w;
    logic [N_CH-1:0]    hit_w;

    assign region = ftl_decode(io_addr, N_CH, RAM_AW);
    assign wr_go  = commit && io_wr;
    assign ch_sel = io_addr[CH_IW-1:0];

    ftl_io_port #(.WAIT_STATES(WAIT_STATES)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_sel   (io_sel),
        .io_ready (io_ready),
        .commit   (commit)
    );

    ftl_frame_counter #(.FRAME_W(FRAME_W), .FRAME_MOD(FRAME_MOD)) u_fc (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_tick (frame_tick),
        .cnt_q      (frame_cnt),
        .cnt_nxt    (cnt_nxt)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        logic sel_i;
        assign sel_i = wr_go && (io_addr[2:0] == 3'(i));

        ftl_channel #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .SPACING(SPACING)) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .frame_tick  (frame_tick),
            .cnt_nxt     (cnt_nxt),
            .stage_we    (sel_i && (region == RG_STAGE)),
            .ref_we      (sel_i && (region == RG_REF)),
            .wdata       (io_wdata),
            .stage_q     (stage_w[i]),
            .ref_q       (ref_w[i]),
            .active_q    (active_w[i]),
            .strobe_q    (ch_strobe[i]),
            .pending_q   (pend_w[i]),
            .busy        (busy_w[i]),
            .xfer        (xfer_w[i]),
            .spacing_hit (hit_w[i])
        );

        assign ch_active[i*DATA_W +: DATA_W] = active_w[i];
    end

    ftl_ramp_seq #(.DATA_W(DATA_W), .RAM_AW(RAM_AW)) u_ramp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ram_we    (wr_go && (region == RG_RAM)),
        .ram_waddr (io_addr[RAM_AW-1:0]),
        .ram_wdata (io_wdata),
        .ram_raddr (io_addr[RAM_AW-1:0]),
        .ram_rdata (ram_rdata),
        .start     (xfer_w[0]),
        .start_idx (stage_w[0][RAM_AW-1:0]),
        .len       (len_q),
        .step_tick (step_tick),
        .level_q   (ramp_level),
        .run_q     (ramp_run)
    );

    // Ramp length register.
    always_ff @(posedge clk) begin
        if (!rst_n)                              len_q <= '0;
        else if (wr_go && (region == RG_LEN))    len_q <= io_wdata[RAM_AW:0];
    end

    // One-cycle flag for a staging write made inside a busy window.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= |hit_w;
    end
    assign spacing_err = err_q;

    // Read-back multiplexer.
    always_comb begin
        io_rdata = '0;
        unique case (region)
            RG_STAGE: io_rdata = stage_w[ch_sel];
            RG_REF:   io_rdata[FRAME_W-1:0] = ref_w[ch_sel];
            RG_LEN:   io_rdata[RAM_AW:0] = len_q;
            RG_STAT: begin
                io_rdata[N_CH-1:0]      = pend_w;
                io_rdata[2*N_CH-1:N_CH] = busy_w;
            end
            RG_RAM:   io_rdata = ram_rdata;
            default:  io_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ftl_checker.sv
// Module: property checker for the frame-timed loader, bound to the top.
// Assumes it sees the pending flags of the channels and the top-level ports.
module ftl_checker #(
    parameter int FRAME_W   = 6,
    parameter int FRAME_MOD = 52,
    parameter int N_CH      = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               frame_tick,
    input logic               step_tick,
    input logic [FRAME_W-1:0] frame_cnt,
    input logic [N_CH-1:0]    ch_strobe,
    input logic [N_CH-1:0]    pending,
    input logic               io_sel,
    input logic               io_ready,
    input logic               ramp_run
);
    AST_FRAME_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(frame_cnt) < FRAME_MOD); // R2
    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick && (int'(frame_cnt) == FRAME_MOD - 1) |=> frame_cnt == '0); // R2
    AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> $stable(frame_cnt)); // R2
    AST_READY_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        io_ready |-> io_sel && $past(io_sel)); // R3
    AST_STROBE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_strobe) |-> $past(frame_tick)); // R5
    AST_RAMP_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ramp_run) |-> $past(step_tick) || ch_strobe[0]); // R9

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        AST_STROBE_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
            ch_strobe[i] |-> $past(pending[i])); // R7
    end
endmodule

bind frame_timed_loader ftl_checker #(
    .FRAME_W   (FRAME_W),
    .FRAME_MOD (FRAME_MOD),
    .N_CH      (N_CH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_tick (frame_tick),
    .step_tick  (step_tick),
    .frame_cnt  (frame_cnt),
    .ch_strobe  (ch_strobe),
    .pending    (pend_w),
    .io_sel     (io_sel),
    .io_ready   (io_ready),
    .ramp_run   (ramp_run)
);

// File: tb/tb_frame_timed_loader.sv
// Bench: behavioural reference model compared on every clock, plus directed checks.
module tb_frame_timed_loader;
    localparam int DW = 12;
    localparam int FW = 4;
    localparam int FM = 12;
    localparam int NC = 4;
    localparam int RAW = 3;
    localparam int RD = 8;
    localparam int SP = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_tick = 1'b0;
    logic step_tick = 1'b0;
    logic io_sel = 1'b0;
    logic io_wr = 1'b0;
    logic [5:0] io_addr = '0;
    logic [DW-1:0] io_wdata = '0;
    logic [DW-1:0] io_rdata;
    logic io_ready;
    logic [FW-1:0] frame_cnt;
    logic [NC*DW-1:0] ch_active;
    logic [NC-1:0] ch_strobe;
    logic [DW-1:0] ramp_level;
    logic ramp_run;
    logic spacing_err;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    bit tick_en = 1'b0;
    int cyc = 0;

    always #10 clk = ~clk;

    frame_timed_loader #(
        .DATA_W(DW), .FRAME_W(FW), .FRAME_MOD(FM), .N_CH(NC),
        .RAM_AW(RAW), .WAIT_STATES(2), .SPACING(SP)
    ) dut (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .step_tick(step_tick),
        .io_sel(io_sel), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .io_ready(io_ready), .frame_cnt(frame_cnt),
        .ch_active(ch_active), .ch_strobe(ch_strobe), .ramp_level(ramp_level),
        .ramp_run(ramp_run), .spacing_err(spacing_err)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    endtask

    // Reference model state.
    int m_fc, m_len, m_lvl, m_idx, m_left, m_wcnt;
    int m_stage[NC], m_ref[NC], m_act[NC], m_busy[NC];
    bit m_pend[NC], m_strobe[NC];
    bit m_run, m_err;
    int m_ram[RD];

    // Model update at each rising edge from the inputs the bench drove.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_fc = 0; m_len = 0; m_lvl = 0; m_idx = 0; m_left = 0; m_wcnt = 0;
            m_run = 0; m_err = 0;
            for (int i = 0; i < NC; i++) begin
                m_stage[i] = 0; m_ref[i] = 0; m_act[i] = 0; m_busy[i] = 0;
                m_pend[i] = 0; m_strobe[i] = 0;
            end
        end else begin
            int nxt;
            bit go;
            bit start0;
            int old_stage0;
            int a;
            go = io_sel && (m_wcnt == 2) && io_wr;
            if (!io_sel || m_wcnt == 2) m_wcnt = 0; else m_wcnt++;
            nxt = frame_tick ? ((m_fc == FM - 1) ? 0 : m_fc + 1) : m_fc;
            old_stage0 = m_stage[0];
            start0 = 0;
            for (int i = 0; i < NC; i++) begin
                m_strobe[i] = frame_tick && m_pend[i] && (nxt == m_ref[i]);
                if (m_strobe[i]) begin
                    m_act[i] = m_stage[i];
                    m_pend[i] = 0;
                end
                if (m_busy[i] > 0) m_busy[i]--;
            end
            start0 = m_strobe[0];
            m_fc = nxt;
            if (start0) begin
                m_idx = old_stage0 % RD;
                m_left = m_len;
                m_run = (m_len != 0);
            end else if (step_tick && m_run) begin
                m_lvl = m_ram[m_idx];
                m_idx = (m_idx + 1) % RD;
                m_left--;
                if (m_left == 0) m_run = 0;
            end
            m_err = 0;
            a = int'(io_addr);
            if (go) begin
                if (a < NC) begin
                    // busy was already decremented above; undo to judge the window
                    if (m_busy[a] > 0 || m_busyPrev(a)) m_err = 1;
                    m_stage[a] = int'(io_wdata);
                    m_pend[a] = 1;
                    m_busy[a] = SP;
                end else if (a >= 8 && a < 8 + NC) begin
                    m_ref[a-8] = int'(io_wdata) % (1 << FW);
                end else if (a == 16) begin
                    m_len = int'(io_wdata) % (1 << (RAW + 1));
                end else if (a >= 32 && a < 32 + RD) begin
                    m_ram[a-32] = int'(io_wdata);
                end
            end
        end
    end

    // Busy state before this edge's decrement: nonzero count left was >= 1.
    int m_busy_prev[NC];
    function automatic bit m_busyPrev(input int ch);
        return m_busy_prev[ch] > 0;
    endfunction
    always @(negedge clk) for (int i = 0; i < NC; i++) m_busy_prev[i] = m_busy[i];

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(int'(frame_cnt) == m_fc, "R2 frame_cnt", frame_cnt, m_fc);
            for (int i = 0; i < NC; i++) begin
                chk(int'(ch_active[i*DW +: DW]) == m_act[i], "R5 ch_active",
                    ch_active[i*DW +: DW], m_act[i]);
                chk(ch_strobe[i] == m_strobe[i], "R5 ch_strobe", ch_strobe[i], m_strobe[i]);
            end
            chk(int'(ramp_level) == m_lvl, "R9 ramp_level", ramp_level, m_lvl);
            chk(ramp_run == m_run, "R9 ramp_run", ramp_run, m_run);
            chk(spacing_err == m_err, "R10 spacing_err", spacing_err, m_err);
        end
    end

    // Stimulus for the frame and step ticks.
    always @(negedge clk) begin
        frame_tick <= tick_en && (cyc % 3 == 0);
        step_tick  <= (cyc % 2 == 1);
        cyc <= cyc + 1;
    end

    bit last_err;

    task automatic io_write(input int addr, input int data);
        int waits;
        @(negedge clk);
        io_sel = 1; io_wr = 1; io_addr = 6'(addr); io_wdata = DW'(data);
        waits = 0;
        do begin
            @(negedge clk);
            waits++;
        end while (!io_ready && waits < 10);
        chk(waits == 2, "R3 wait states on write", waits, 2);
        @(negedge clk);
        last_err = spacing_err;
        io_sel = 0; io_wr = 0;
    endtask

    task automatic io_read(input int addr, output int data);
        int waits;
        @(negedge clk);
        io_sel = 1; io_wr = 0; io_addr = 6'(addr);
        waits = 0;
        do begin
            @(negedge clk);
            waits++;
        end while (!io_ready && waits < 10);
        chk(waits == 2, "R3 wait states on read", waits, 2);
        data = int'(io_rdata);
        @(negedge clk);
        io_sel = 0;
    endtask

    task automatic wait_strobe(input int ch, output bit seen);
        seen = 0;
        for (int k = 0; k < 200 && !seen; k++) begin
            @(negedge clk);
            if (ch_strobe[ch]) seen = 1;
        end
    endtask

    int rd;
    bit seen;

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(frame_cnt == 0, "R1 frame_cnt", frame_cnt, 0);
        chk(ch_active == 0, "R1 ch_active", ch_active, 0);
        chk(ch_strobe == 0, "R1 ch_strobe", ch_strobe, 0);
        chk(ramp_run == 0 && ramp_level == 0, "R1 ramp", ramp_level, 0);
        chk(io_ready == 0 && spacing_err == 0, "R1 ready/err", io_ready, 0);
        rst_n = 1;
        io_read(17, rd);
        chk(rd == 0, "R1 R11 status after reset", rd, 0);

        // R2: counter runs and wraps
        tick_en = 1;
        begin
            bit wrapped = 0;
            int prev = int'(frame_cnt);
            for (int k = 0; k < 60; k++) begin
                @(negedge clk);
                if (prev == FM - 1 && frame_cnt == 0) wrapped = 1;
                prev = int'(frame_cnt);
            end
            chk(wrapped, "R2 wrap to zero", wrapped, 1);
        end

        // R4, R5, R11: stage channel 1 and let it transfer
        tick_en = 0;
        io_write(8 + 1, 5);
        io_read(8 + 1, rd);
        chk(rd == 5, "R11 reference read-back", rd, 5);
        io_write(1, 12'h123);
        chk(ch_active[DW +: DW] == 0, "R4 active unchanged", ch_active[DW +: DW], 0);
        io_read(17, rd);
        chk(rd[1] == 1, "R4 R11 pending bit", rd[1], 1);
        tick_en = 1;
        wait_strobe(1, seen);
        chk(seen, "R5 strobe seen", seen, 1);
        chk(ch_active[DW +: DW] == 12'h123, "R5 transferred value", ch_active[DW +: DW], 12'h123);
        chk(frame_cnt == 5, "R5 frame_cnt equals reference", frame_cnt, 5);
        io_read(17, rd);
        chk(rd[1] == 0, "R5 pending cleared", rd[1], 0);

        // R7: no further strobe without a new write
        begin
            bit extra = 0;
            for (int k = 0; k < 90; k++) begin
                @(negedge clk);
                if (ch_strobe[1]) extra = 1;
            end
            chk(!extra, "R7 no strobe when idle", extra, 0);
        end

        // R6: rewrite while pending
        tick_en = 0;
        io_write(8 + 2, 7);
        io_write(2, 12'h0AA);
        repeat (SP + 2) @(negedge clk);
        io_write(2, 12'h0BB);
        chk(!last_err, "R10 spaced write not flagged", last_err, 0);
        tick_en = 1;
        wait_strobe(2, seen);
        chk(seen && ch_active[2*DW +: DW] == 12'h0BB, "R6 last value transferred",
            ch_active[2*DW +: DW], 12'h0BB);

        // R8: out-of-range reference never matches
        tick_en = 0;
        io_write(8 + 3, 13);
        io_write(3, 12'h3CC);
        tick_en = 1;
        begin
            bit hit = 0;
            for (int k = 0; k < 100; k++) begin
                @(negedge clk);
                if (ch_strobe[3]) hit = 1;
            end
            chk(!hit, "R8 no match beyond modulus", hit, 0);
        end
        io_read(17, rd);
        chk(rd[3] == 1, "R8 still pending", rd[3], 1);
        chk(ch_active[3*DW +: DW] == 0, "R8 active unchanged", ch_active[3*DW +: DW], 0);

        // R10, R11: back-to-back staging writes
        tick_en = 0;
        io_write(1, 12'h111);
        chk(!last_err, "R10 first write clean", last_err, 0);
        io_write(1, 12'h222);
        chk(last_err, "R10 spacing violation flagged", last_err, 1);
        io_read(17, rd);
        chk(rd[NC+1] == 1, "R10 R11 busy bit", rd[NC+1], 1);
        io_read(1, rd);
        chk(rd == 12'h222, "R10 second write accepted", rd, 12'h222);
        tick_en = 1;
        wait_strobe(1, seen);
        chk(ch_active[DW +: DW] == 12'h222, "R6 R10 transfer of latest", ch_active[DW +: DW], 12'h222);

        // R9: ramp playout wrapping around the RAM end
        tick_en = 0;
        for (int k = 0; k < RD; k++) io_write(32 + k, k * 12'h101 + 3);
        io_read(32 + 6, rd);
        chk(rd == 6 * 12'h101 + 3, "R11 RAM read-back", rd, 6 * 12'h101 + 3);
        io_write(16, 5);
        io_write(8 + 0, 4);
        io_write(0, 6);
        tick_en = 1;
        wait_strobe(0, seen);
        chk(seen && ramp_run, "R9 ramp starts on transfer", ramp_run, 1);
        for (int k = 0; k < 100 && ramp_run; k++) @(negedge clk);
        chk(!ramp_run, "R9 ramp stops", ramp_run, 0);
        chk(ramp_level == 2 * 12'h101 + 3, "R9 last entry after wrap", ramp_level, 2 * 12'h101 + 3);

        // R12: zero-length ramp
        tick_en = 0;
        io_write(16, 0);
        io_write(8 + 0, 2);
        io_write(0, 1);
        tick_en = 1;
        wait_strobe(0, seen);
        begin
            bit ran = 0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (ramp_run) ran = 1;
            end
            chk(seen && !ran, "R12 zero length keeps ramp idle", ran, 0);
        end

        repeat (5) @(negedge clk);
        summary();
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end
endmodule